// File: doc/BRIEF.md
# Read-Sequence Store/Recall Trigger

This block watches the access stream of a parallel SRAM port. Each access is marked by a one-cycle strobe, a write flag and a 16-bit address. It looks for a fixed run of six reads. The first five addresses are the same for both operations. The sixth address decides the operation: one value starts a nonvolatile store and another starts a nonvolatile recall.

The run is strict. A write anywhere in the run cancels it without any sign at the outputs. A read at an address that does not fit the current step also cancels it. The exception is a read at the first key address, which starts the run again at step one.

When a run completes, the block gives a single-cycle start pulse for the chosen operation. It then holds a disable output for a fixed number of cycles, `OP_CYCLES`. A counter stands in for the nonvolatile operation. While the disable output is high, the matcher ignores all bus traffic. After the window it waits at step zero.

Top module: `nvseq_detect`

## Requirements
- R1: The five lead-in keys are 16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F and 16'h703F. They must be read in that order, and only a completed run can start an operation.
- R2: A sixth read at 16'h8FC0 pulses `store_go` high for exactly one cycle, the cycle after the strobed access. A sixth read at 16'h4C63 pulses `recall_go` the same way. The two pulses are never high together.
- R3: A strobed access with `acc_wr`=1 at any step cancels the run, including a write at the sixth address. That access and the rest of that run start nothing.
- R4: A strobed read at an address that is not the key for the current step cancels the run. The later keys of that run then start nothing.
- R5: A strobed read at 16'h4E38 in the middle of a run restarts matching at step one, so the next five keys complete a run.
- R6: Cycles with `acc_vld`=0 neither advance nor cancel the run, whatever `acc_wr` and `acc_addr` hold.
- R7: `bus_disable` goes high in the same cycle as the start pulse. It stays high for exactly `OP_CYCLES` cycles and then falls.
- R8: Accesses made while `bus_disable` is high are ignored. After the window the matcher is at step zero, so the remaining keys of a run begun during the window start nothing.
- R9: After reset, `store_go`, `recall_go` and `bus_disable` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 16 | Access address |
| store_go | output | 1 | One-cycle store start pulse |
| recall_go | output | 1 | One-cycle recall start pulse |
| bus_disable | output | 1 | High while the modelled operation runs |

## Verification
The assertions assume `acc_wr` and `acc_addr` matter only in cycles where `acc_vld` is high. They also assume each access is held for exactly one strobed cycle. The bench drives every access on the falling edge, keeps the strobe high for a single rising edge, and lowers it before the next one. Idle gaps between accesses carry stale address values with the strobe low, which exercises the qualification. Sweeps that break a run at each of the six steps, with both a write and a stray read, never let two operations overlap. Each sweep waits out the disable window before the next begins.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
    localparam int ADDR_W    = 16;
    localparam int KEY_COUNT = 5;

    localparam logic [ADDR_W-1:0] STORE_KEY  = 16'h8FC0;
    localparam logic [ADDR_W-1:0] RECALL_KEY = 16'h4C63;

    // Lead-in key for a given step; the order is behaviour.
    function automatic logic [ADDR_W-1:0] key_addr(input int idx);
        case (idx)
            0:       return 16'h4E38;
            1:       return 16'hB1C7;
            2:       return 16'h83E0;
            3:       return 16'h7C1F;
            default: return 16'h703F;
        endcase
    endfunction
endpackage

// File: rtl/nvseq_key_cmp.sv
module nvseq_key_cmp
    import nvseq_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    output logic [KEY_COUNT-1:0] key_hit,
    output logic                 store_hit,
    output logic                 recall_hit
);
    for (genvar g = 0; g < KEY_COUNT; g++) begin : g_key
        assign key_hit[g] = (addr == key_addr(g));
    end

    assign store_hit  = (addr == STORE_KEY);
    assign recall_hit = (addr == RECALL_KEY);
endmodule

// File: rtl/nvseq_matcher.sv
module nvseq_matcher
    import nvseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_ok,
    input  logic                 acc_wr,
    input  logic [KEY_COUNT-1:0] key_hit,
    input  logic                 store_hit,
    input  logic                 recall_hit,
    output logic                 launch_store,
    output logic                 launch_recall
);
    localparam int STEP_W = $clog2(KEY_COUNT + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_COUNT);

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } mstate_t;

    mstate_t st_d, st_q;
    logic    adv;

    always_comb begin
        adv = 1'b0;
        for (int i = 0; i < KEY_COUNT; i++) begin
            if (st_q.step == STEP_W'(i) && key_hit[i]) adv = 1'b1;
        end
    end

    always_comb begin
        st_d          = st_q;
        launch_store  = 1'b0;
        launch_recall = 1'b0;
        if (acc_ok) begin
            if (acc_wr) begin
                st_d.step = '0;
            end else if (st_q.step == LAST_STEP) begin
                launch_store  = store_hit;
                launch_recall = recall_hit;
                st_d.step     = key_hit[0] ? STEP_W'(1) : '0;
            end else if (adv) begin
                st_d.step = st_q.step + STEP_W'(1);
            end else begin
                st_d.step = key_hit[0] ? STEP_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/nvseq_op_timer.sv
module nvseq_op_timer #(
    parameter int OP_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_store,
    input  logic launch_recall,
    output logic store_go,
    output logic recall_go,
    output logic busy
);
    localparam int CNT_W = $clog2(OP_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic             store_go;
        logic             recall_go;
        logic [CNT_W-1:0] cnt;
    } tstate_t;

    tstate_t t_d, t_q;

    always_comb begin
        t_d           = t_q;
        t_d.store_go  = 1'b0;
        t_d.recall_go = 1'b0;
        if (launch_store || launch_recall) begin
            t_d.busy      = 1'b1;
            t_d.cnt       = CNT_W'(OP_CYCLES - 1);
            t_d.store_go  = launch_store;
            t_d.recall_go = launch_recall;
        end else if (t_q.busy) begin
            if (t_q.cnt == '0) t_d.busy = 1'b0;
            else               t_d.cnt  = t_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign store_go  = t_q.store_go;
    assign recall_go = t_q.recall_go;
    assign busy      = t_q.busy;
endmodule

// File: rtl/nvseq_detect.sv
module nvseq_detect #(
    parameter int OP_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_vld,
    input  logic        acc_wr,
    input  logic [15:0] acc_addr,
    output logic        store_go,
    output logic        recall_go,
    output logic        bus_disable
);
    import nvseq_pkg::*;

    logic [KEY_COUNT-1:0] key_hit;
    logic                 store_hit, recall_hit;
    logic                 launch_store, launch_recall;
    logic                 busy;
    logic                 acc_ok;

    assign acc_ok = acc_vld && !busy;

    nvseq_key_cmp u_cmp (
        .addr       (acc_addr),
        .key_hit    (key_hit),
        .store_hit  (store_hit),
        .recall_hit (recall_hit)
    );

    nvseq_matcher u_match (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_ok        (acc_ok),
        .acc_wr        (acc_wr),
        .key_hit       (key_hit),
        .store_hit     (store_hit),
        .recall_hit    (recall_hit),
        .launch_store  (launch_store),
        .launch_recall (launch_recall)
    );

    nvseq_op_timer #(.OP_CYCLES(OP_CYCLES)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .launch_store  (launch_store),
        .launch_recall (launch_recall),
        .store_go      (store_go),
        .recall_go     (recall_go),
        .busy          (busy)
    );

    assign bus_disable = busy;
endmodule

// File: rtl/nvseq_detect_chk.sv
module nvseq_detect_chk #(
    parameter int OP_CYCLES = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_vld,
    input logic        acc_wr,
    input logic [15:0] acc_addr,
    input logic        store_go,
    input logic        recall_go,
    input logic        bus_disable
);
    int dis_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)           dis_cnt <= 0;
        else if (bus_disable) dis_cnt <= dis_cnt + 1;
        else                  dis_cnt <= 0;
    end

    assert_one_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_go && recall_go));

    assert_store_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |=> !store_go);

    assert_recall_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        recall_go |=> !recall_go);

    assert_store_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |-> $past(acc_vld && !acc_wr && acc_addr == 16'h8FC0));

    assert_recall_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        recall_go |-> $past(acc_vld && !acc_wr && acc_addr == 16'h4C63));

    assert_write_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_wr) |=> !(store_go || recall_go));

    assert_idle_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld |=> !(store_go || recall_go));

    assert_go_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (store_go || recall_go) |-> bus_disable);

    assert_disable_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_disable) |-> (store_go || recall_go));

    assert_disable_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dis_cnt <= OP_CYCLES);

    assert_quiet_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_disable && !store_go && !recall_go) |=> !(store_go || recall_go) || !$past(bus_disable));
endmodule

bind nvseq_detect nvseq_detect_chk #(.OP_CYCLES(OP_CYCLES)) u_chk (.*);

// File: tb/tb_nvseq_detect.sv
module tb_nvseq_detect;
    localparam int CLK_PERIOD = 10;
    localparam int OPC        = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_vld = 1'b0;
    logic        acc_wr = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        store_go, recall_go, bus_disable;

    int n_checks = 0;
    int n_fail   = 0;
    logic sg, rg, dis;

    nvseq_detect #(.OP_CYCLES(OPC)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] lead(input int i);
        logic [15:0] t [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
        return t[i];
    endfunction

    function automatic logic [15:0] fin(input int kind);
        return (kind == 0) ? 16'h8FC0 : 16'h4C63;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [15:0] a);
        @(negedge clk);
        acc_vld = 1'b1; acc_wr = wr; acc_addr = a;
        @(posedge clk); #1;
        sg = store_go; rg = recall_go; dis = bus_disable;
        acc_vld = 1'b0;
    endtask

    task automatic wait_idle();
        while (bus_disable) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic lead_in(input int n);
        for (int i = 0; i < n; i++) acc(1'b0, lead(i));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!store_go && !recall_go && !bus_disable, "R9 reset outputs",
              {store_go, recall_go, bus_disable}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R1/R2 store with pulse width, R7 window length
        lead_in(5); acc(1'b0, fin(0));
        check(sg && !rg && dis, "R2 store pulse", {sg, rg, dis}, 3'b101);
        begin
            int len = 1;
            @(posedge clk); #1;
            check(!store_go, "R2 store one cycle", store_go, 0);
            while (bus_disable) begin len++; @(posedge clk); #1; end
            check(len == OPC, "R7 disable length", len, OPC);
        end

        // R2 recall
        lead_in(5); acc(1'b0, fin(1));
        check(rg && !sg && dis, "R2 recall pulse", {sg, rg, dis}, 3'b011);
        @(posedge clk); #1;
        check(!recall_go, "R2 recall one cycle", recall_go, 0);
        wait_idle();

        // R1 wrong order: keys 1 and 2 swapped
        acc(1'b0, lead(0)); acc(1'b0, lead(2)); acc(1'b0, lead(1));
        acc(1'b0, lead(3)); acc(1'b0, lead(4)); acc(1'b0, fin(0));
        check(!sg && !rg, "R1 order enforced", {sg, rg}, 0);

        // R3/R4 sweep: break at each step p, then finish the keys
        for (int kind = 0; kind < 2; kind++)
            for (int d = 0; d < 2; d++)
                for (int p = 0; p < 6; p++) begin
                    logic [15:0] brk;
                    logic e;
                    brk = (p < 5) ? lead(p) : fin(kind);
                    lead_in(p);
                    if (d == 0) acc(1'b1, brk);
                    else        acc(1'b0, 16'h1234);
                    for (int i = p; i < 5; i++) acc(1'b0, lead(i));
                    acc(1'b0, fin(kind));
                    e = (p == 0);
                    check(sg == (e && kind == 0) && rg == (e && kind == 1),
                          d == 0 ? "R3 write abort" : "R4 stray read abort",
                          {sg, rg}, {e && kind == 0, e && kind == 1});
                    wait_idle();
                end

        // R5 restart on 4E38 mid-run
        lead_in(3); acc(1'b0, 16'h4E38);
        for (int i = 1; i < 5; i++) acc(1'b0, lead(i));
        acc(1'b0, fin(0));
        check(sg, "R5 restart at step one", sg, 1);
        wait_idle();
        lead_in(5); acc(1'b0, 16'h4E38);
        for (int i = 1; i < 5; i++) acc(1'b0, lead(i));
        acc(1'b0, fin(1));
        check(rg, "R5 restart from last step", rg, 1);
        wait_idle();

        // R6 long idle gaps with junk on the bus, strobe low
        for (int i = 0; i < 5; i++) begin
            acc(1'b0, lead(i));
            @(negedge clk); acc_wr = 1'b1; acc_addr = 16'hFFFF;
            repeat (4) @(negedge clk);
        end
        acc(1'b0, fin(0));
        check(sg, "R6 strobe-low cycles ignored", sg, 1);

        // R8 accesses inside the window are ignored
        lead_in(3);
        check(bus_disable, "R8 still in window", bus_disable, 1);
        wait_idle();
        acc(1'b0, lead(3)); acc(1'b0, lead(4)); acc(1'b0, fin(0));
        check(!sg && !rg, "R8 window traffic ignored", {sg, rg}, 0);
        lead_in(5); acc(1'b0, fin(1));
        check(rg, "R8 matcher usable after window", rg, 1);
        wait_idle();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule